// File: doc/BRIEF.md
# Two-Backplane Segment LCD Waveform Driver

This block drives a segment LCD glass with two common backplanes directly from digital pins. Each segment pin serves two segments, one on each backplane, so the block holds two data bits per segment pin. A programmable divider produces a phase update at a fixed interval. Each frame has four equal phases. In every phase one common pin is driven to an active level, either high or low. The other common pin floats at a middle level, which an off-chip resistor divider supplies. Each segment pin carries the data bit for the active backplane, either true or inverted, so the voltage across every segment averages to zero over a frame.

The pin values for the next phase are computed during the current phase and held in a shadow register. At the next tick they reach the pins in a single clock edge. Pin timing therefore depends only on the divider and never on how long the computation takes. The common state is kept in an internal image. It advances by XOR with a flip mask, and the mask alternates between two values because a signed step is added and then negated on each phase. When the block is disabled or in reset, every pin is held at the same level, so the glass carries no voltage.

Top module: `lcd_bp2_driver`

## Requirements
- R1: After `enable` is sampled high, the first phase update happens on the TICK_DIV-th enabled clock edge. Each following update comes exactly TICK_DIV edges after the previous one.
- R2: The pins change only on a tick edge, or on an edge where `enable` is sampled low. They hold their value on every other edge.
- R3: Each common pin is encoded as a drive bit and a level bit in `com_drv_o[i]` and `com_lvl_o[i]`. Drive 0 means idle (middle level), and its level bit then reads 0. The four phases run in a fixed order. Phase 0: common 0 high, common 1 idle. Phase 1: common 1 high, common 0 idle. Phase 2: common 0 low, common 1 idle. Phase 3: common 1 low, common 0 idle. The order then repeats.
- R4: In phases 0 and 2, segment pin k carries plane-0 bit `seg_data[k]`. In phases 1 and 3 it carries plane-1 bit `seg_data[NSEG+k]`. A data bit of 1 puts the segment pin at the opposite level to the active common. A data bit of 0 puts it at the same level.
- R5: While phases are running, exactly one common pin is driven at any time.
- R6: Over every complete frame, the sum of (segment level minus common level) is zero for every segment pin against each common. The levels count as low 0, idle 1 and high 2.
- R7: In reset, and on every edge after `enable` is sampled low, all segment pins are 0 and both commons are driven low.
- R8: `seg_data` is sampled only once per frame, one edge after the tick that starts phase 3, or on the first enabled edge. A change at any other time first appears in the next phase 0.
- R9: When `enable` goes low and then high again, the sequence restarts at phase 0 with the R1 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the phase sequence; low forces the neutral pin state |
| seg_data | input | 2*NSEG | Low half: plane-0 bits; high half: plane-1 bits |
| seg_o | output | NSEG | Segment pin levels |
| com_drv_o | output | 2 | Common pin drive enables (0 = idle middle level) |
| com_lvl_o | output | 2 | Common pin levels when driven |

## Verification
A wrong image bit or flip mask shows up at the next tick as the wrong common being driven, or as the wrong polarity. The per-clock comparison then fails within one phase interval. The same fault also breaks the frame-sum balance by the end of that frame. A wrong plane pointer or frame-data latch shows up only on segment pins whose two plane bits differ, or when data changes mid-frame. The stimulus therefore uses asymmetric patterns and writes at unaligned cycles. A divider that is off by one shifts every pin edge, which the first tick after enable exposes.

// File: rtl/lcd_bp2_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the two-backplane LCD driver.
// Assumes exactly two commons; the phase image encodes polarity and
// which common is active.
package lcd_bp2_pkg;

    localparam int IMG_W = 3;
    localparam int MSK_W = 4;

    // Phase image: polarity (1 = active common low) and active-common flags
    typedef struct packed {
        logic pol;
        logic act_b;
        logic act_a;
    } img_t;

    // Encoded pair of common pins
    typedef struct packed {
        logic [1:0] drv;
        logic [1:0] lvl;
    } com_t;

    // Image of the last phase of a frame; the sequencer idles here
    localparam img_t IMG_LAST = '{pol: 1'b1, act_b: 1'b1, act_a: 1'b0};

    // Flip mask that leads from phase 3 into phase 0, and the step that
    // follows it (-4 in MSK_W bits)
    localparam logic [MSK_W-1:0] MASK_INIT = 4'b0111;
    localparam logic [MSK_W-1:0] STEP_INIT = 4'b1100;

    // Neutral pin state: both commons driven low
    localparam com_t COM_NEUTRAL = '{drv: 2'b11, lvl: 2'b00};

    // Map a phase image onto the common pin encoding
    function automatic com_t com_of(input img_t im);
        com_t c;
        c.drv = {im.act_b, im.act_a};
        c.lvl = {im.act_b & ~im.pol, im.act_a & ~im.pol};
        return c;
    endfunction

endpackage

// File: rtl/lcd_bp2_tick.sv
`timescale 1ns/1ps
// Phase interval divider. Emits a one-cycle tick every DIV enabled
// clocks, the first on the DIV-th enabled edge. It is held cleared while
// run is low. Assumes DIV >= 3 so that a shadow update fits between ticks.
module lcd_bp2_tick #(
    parameter int DIV = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    // Count enabled clocks, wrapping at the interval length
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/lcd_bp2_seq.sv
`timescale 1ns/1ps
// Phase sequencer. Holds the image of the phase now on the pins, the
// plane pointer, the flip mask and its signed step. At each tick it XORs
// the mask into the image, adds the step to the mask and negates the step.
// It presents the next phase's image and pointer for the shadow stage.
// It returns to the phase-3 image whenever run is low.
module lcd_bp2_seq
    import lcd_bp2_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output img_t nxt_img_o,
    output logic nxt_ptr_o
);
    img_t             img_q;
    logic             ptr_q;
    logic [MSK_W-1:0] mask_q;
    logic [MSK_W-1:0] step_q;

    assign nxt_img_o = img_t'(img_q ^ mask_q[IMG_W-1:0]);
    assign nxt_ptr_o = ~ptr_q;

    // Advance image, pointer, mask and step once per tick
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            img_q  <= IMG_LAST;
            ptr_q  <= 1'b1;
            mask_q <= MASK_INIT;
            step_q <= STEP_INIT;
        end else if (tick) begin
            img_q  <= nxt_img_o;
            ptr_q  <= ~ptr_q;
            mask_q <= mask_q + step_q;
            step_q <= ~step_q + 1'b1;
        end
    end

    // R3
    mask_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 4'b0011) || (mask_q == 4'b0111));

    // R5
    one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({img_q.act_b, img_q.act_a}));

    // R4
    ptr_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q == img_q.act_b);

endmodule

// File: rtl/lcd_bp2_out.sv
`timescale 1ns/1ps
// Shadow and pin stage. One edge after each tick, and on the first enabled
// edge, it computes the next phase's pin values into a shadow register. It
// applies them at the next tick in one edge. Segment data is latched only
// when the coming phase is phase 0. While run is low, the pins are neutral.
module lcd_bp2_out
    import lcd_bp2_pkg::*;
#(
    parameter int NSEG = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  img_t            nxt_img,
    input  logic            nxt_ptr,
    input  logic [2*NSEG-1:0] seg_data,
    output logic [NSEG-1:0] seg_o,
    output logic [1:0]      com_drv_o,
    output logic [1:0]      com_lvl_o
);
    logic              en_q;
    logic              tick_q;
    logic              live_q;
    logic              calc;
    logic              to_p0;
    logic [2*NSEG-1:0] frame_q;
    logic [2*NSEG-1:0] src;
    logic [NSEG-1:0]   seg_nxt;
    logic [NSEG-1:0]   shd_seg_q;
    logic [NSEG-1:0]   seg_q;
    com_t              shd_com_q;
    com_t              com_q;

    assign calc  = run && (tick_q || !en_q);
    assign to_p0 = nxt_img.act_a && !nxt_img.pol;
    assign src   = to_p0 ? seg_data : frame_q;

    // Per-pin plane selection and polarity
    for (genvar k = 0; k < NSEG; k++) begin : g_pin
        logic bit_sel;
        assign bit_sel    = nxt_ptr ? src[NSEG+k] : src[k];
        assign seg_nxt[k] = nxt_img.pol ? bit_sel : ~bit_sel;
    end

    // Remember enable and the tick to schedule the shadow update
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            en_q   <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            en_q   <= 1'b1;
            tick_q <= tick;
        end
    end

    // Compute the coming phase into the shadow and latch frame data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q   <= '0;
            shd_seg_q <= '0;
            shd_com_q <= COM_NEUTRAL;
        end else if (calc) begin
            if (to_p0) begin
                frame_q <= seg_data;
            end
            shd_seg_q <= seg_nxt;
            shd_com_q <= com_of(nxt_img);
        end
    end

    // Apply the shadow to the pins at the tick
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            seg_q  <= '0;
            com_q  <= COM_NEUTRAL;
            live_q <= 1'b0;
        end else if (tick) begin
            seg_q  <= shd_seg_q;
            com_q  <= shd_com_q;
            live_q <= 1'b1;
        end
    end

    assign seg_o     = seg_q;
    assign com_drv_o = com_q.drv;
    assign com_lvl_o = com_q.lvl;

    // R7
    neutral_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (seg_o == '0 && com_drv_o == 2'b11 && com_lvl_o == 2'b00));

    // R2
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> ($stable(seg_o) && $stable(com_drv_o) && $stable(com_lvl_o)));

    // R5
    single_common_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> $countones(com_drv_o) == 1);

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (com_lvl_o & ~com_drv_o) == 2'b00);

endmodule

// File: rtl/lcd_bp2_driver.sv
`timescale 1ns/1ps
// Top level of the two-backplane LCD waveform driver. The divider sets the
// phase interval, the sequencer walks the four-phase frame, and the output
// stage precomputes and applies pin values. Assumes TICK_DIV >= 3. The
// middle level for idle commons is supplied off-chip.
module lcd_bp2_driver
    import lcd_bp2_pkg::*;
#(
    parameter int NSEG     = 8,
    parameter int TICK_DIV = 2_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [2*NSEG-1:0] seg_data,
    output logic [NSEG-1:0]   seg_o,
    output logic [1:0]        com_drv_o,
    output logic [1:0]        com_lvl_o
);
    logic tick;
    img_t nxt_img;
    logic nxt_ptr;

    lcd_bp2_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .tick  (tick)
    );

    lcd_bp2_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .tick      (tick),
        .nxt_img_o (nxt_img),
        .nxt_ptr_o (nxt_ptr)
    );

    lcd_bp2_out #(.NSEG(NSEG)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .tick      (tick),
        .nxt_img   (nxt_img),
        .nxt_ptr   (nxt_ptr),
        .seg_data  (seg_data),
        .seg_o     (seg_o),
        .com_drv_o (com_drv_o),
        .com_lvl_o (com_lvl_o)
    );

endmodule

// File: tb/lcd_bp2_driver_test.sv
`timescale 1ns/1ps
module lcd_bp2_driver_test;
    localparam int NS  = 4;
    localparam int DIV = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enable = 1'b0;
    logic [2*NS-1:0] seg_data = '0;
    logic [NS-1:0]   seg_o;
    logic [1:0]      com_drv_o;
    logic [1:0]      com_lvl_o;

    integer checks = 0;
    integer errors = 0;
    integer cycles = 0;
    string  cur_req = "R7";

    lcd_bp2_driver #(.NSEG(NS), .TICK_DIV(DIV)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .seg_data  (seg_data),
        .seg_o     (seg_o),
        .com_drv_o (com_drv_o),
        .com_lvl_o (com_lvl_o)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference: enabled-edge count, phase from tick number
    integer          n = 0;
    integer          ph = 0;
    logic            tick_now = 1'b0;
    logic            live = 1'b0;
    logic            started = 1'b0;
    logic [2*NS-1:0] mdata = '0;
    logic [NS-1:0]   e_seg = '0;
    logic [1:0]      e_drv = 2'b11;
    logic [1:0]      e_lvl = 2'b00;
    integer          acc0 [NS];
    integer          acc1 [NS];

    always @(posedge clk) begin
        tick_now = 1'b0;
        if (!rst_n || !enable) begin
            n = 0; e_seg = '0; e_drv = 2'b11; e_lvl = 2'b00;
            live = 1'b0; started = 1'b0;
        end else begin
            n = n + 1;
            // R8: data sampled once per frame
            if ((n % DIV) == 1 && ((n / DIV) % 4) == 0) mdata = seg_data;
            // R1: tick every DIV enabled edges
            if ((n % DIV) == 0) begin
                tick_now = 1'b1;
                live = 1'b1;
                ph = ((n / DIV) - 1) % 4;
                case (ph)
                    0: begin e_drv = 2'b01; e_lvl = 2'b01; e_seg = ~mdata[NS-1:0]; end
                    1: begin e_drv = 2'b10; e_lvl = 2'b10; e_seg = ~mdata[2*NS-1:NS]; end
                    2: begin e_drv = 2'b01; e_lvl = 2'b00; e_seg = mdata[NS-1:0]; end
                    default: begin e_drv = 2'b10; e_lvl = 2'b00; e_seg = mdata[2*NS-1:NS]; end
                endcase
            end
        end
    end

    function automatic integer com_val(input logic d, input logic l);
        return d ? (l ? 2 : 0) : 1;
    endfunction

    // Compare pins against the reference away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks = checks + 1;
            if (seg_o !== e_seg || com_drv_o !== e_drv || com_lvl_o !== e_lvl) begin
                errors = errors + 1;
                $display("FAIL %s (R1 R2 R3 R4) cycle %0d: seg=%b drv=%b lvl=%b expected seg=%b drv=%b lvl=%b",
                         cur_req, cycles, seg_o, com_drv_o, com_lvl_o, e_seg, e_drv, e_lvl);
            end
            if (live) begin
                checks = checks + 1;
                if ($countones(com_drv_o) != 1) begin
                    errors = errors + 1;
                    $display("FAIL R5 driven commons=%0d expected 1", $countones(com_drv_o));
                end
            end
            // R6: frame DC balance from observed pins
            if (tick_now) begin
                if (ph == 0) begin
                    started = 1'b1;
                    for (int k = 0; k < NS; k++) begin acc0[k] = 0; acc1[k] = 0; end
                end
                for (int k = 0; k < NS; k++) begin
                    acc0[k] = acc0[k] + 2 * seg_o[k] - com_val(com_drv_o[0], com_lvl_o[0]);
                    acc1[k] = acc1[k] + 2 * seg_o[k] - com_val(com_drv_o[1], com_lvl_o[1]);
                end
                if (ph == 3 && started) begin
                    for (int k = 0; k < NS; k++) begin
                        checks = checks + 1;
                        if (acc0[k] != 0 || acc1[k] != 0) begin
                            errors = errors + 1;
                            $display("FAIL R6 seg %0d frame sums %0d/%0d expected 0/0", k, acc0[k], acc1[k]);
                        end
                    end
                end
            end
        end else begin
            // R7: reset state
            checks = checks + 1;
            if (seg_o !== '0 || com_drv_o !== 2'b11 || com_lvl_o !== 2'b00) begin
                errors = errors + 1;
                $display("FAIL R7 reset seg=%b drv=%b lvl=%b expected 0/11/00", seg_o, com_drv_o, com_lvl_o);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_cyc(input int c);
        for (int i = 0; i < c; i++) @(negedge clk);
    endtask

    initial begin
        wait_cyc(4);
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R7";
        wait_cyc(6);                         // disabled: neutral pins
        cur_req = "R1 R3 R4";
        seg_data = 8'b1010_0101;
        enable = 1'b1;
        wait_cyc(3 * 4 * DIV);
        cur_req = "R8";                      // unaligned mid-frame writes
        wait_cyc(2);
        seg_data = 8'b1111_0000;
        wait_cyc(7);
        seg_data = 8'b0011_1100;
        wait_cyc(13);
        seg_data = 8'b1111_1111;
        wait_cyc(2 * 4 * DIV);
        seg_data = 8'b0000_0000;
        wait_cyc(2 * 4 * DIV + 3);
        cur_req = "R7 R9";                   // disable mid-frame, re-enable
        enable = 1'b0;
        wait_cyc(5);
        seg_data = 8'b0110_1001;
        enable = 1'b1;
        wait_cyc(3 * 4 * DIV);
        cur_req = "R2 R6";
        for (int r = 0; r < 6; r++) begin
            seg_data = 8'($urandom);
            wait_cyc(4 * DIV + r);
        end
        wait_cyc(2 * 4 * DIV);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule